// File: doc/BRIEF.md
# Valley Counter with Turn-On Request and Overvoltage Latch

In a quasi-resonant flyback controller, the switch is turned back on in one of the troughs of the drain ringing that follows demagnetisation. This block counts those troughs. While the power switch is off, it watches a digital comparator that follows the auxiliary-winding sense voltage. Each time the sense falls through the 100 mV level, it adds one to a 3-bit count. When the count reaches the valley number chosen by the loop above, it raises a one-cycle turn-on request. The count restarts from zero whenever the gate drive goes high.

The same sense path is compared against an overvoltage level. When that comparator stays high during the off-time for a programmable blanking time, the block sets a fault latch. The latch blocks every further turn-on request and clears only on a full reset. Both comparator inputs are asynchronous to the block clock and are synchronized inside it. The gate-drive state comes from the same clock domain and is used directly.

Top module: `valley_counter_top`

## Requirements
- R1: `zc_cmp_i` is 1 while the sense is above 100 mV. A 1-to-0 transition of it while `drive_on_i` is 0 increments `count_o` by one. The new value appears at the third rising clock edge after the input changes, with the default two synchronizer stages.
- R2: `count_o` saturates at 7. Further falling crossings leave it at 7 and never wrap it to 0.
- R3: A 0-to-1 transition of `drive_on_i` clears `count_o` to 0 at the next rising clock edge.
- R4: Falling crossings that reach the counter while `drive_on_i` is 1 leave `count_o` unchanged.
- R5: `turn_on_o` is high for exactly one clock cycle when an increment makes `count_o` equal to `target_i`. It never rises when a crossing finds the count already at 7, or when `target_i` is 0.
- R6: `ovp_cmp_i` has no effect while `drive_on_i` is 1, however long it stays high.
- R7: `fault_o` sets once the synchronized `ovp_cmp_i` has been high with the drive off for `BLANK_CYCLES` consecutive clock cycles. A shorter burst sets nothing, and the next burst starts timing again from zero.
- R8: `fault_o`, once set, stays set until `rst_n` is asserted. While it is set, `turn_on_o` stays 0.
- R9: While `rst_n` is 0, and after it is released, `count_o`, `turn_on_o` and `fault_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_cmp_i | input | 1 | Zero-crossing comparator, 1 = sense above 100 mV (asynchronous) |
| ovp_cmp_i | input | 1 | Overvoltage comparator, 1 = sense above OVP level (asynchronous) |
| drive_on_i | input | 1 | Present gate-drive state, 1 = switch on |
| target_i | input | 3 | Valley number at which to request turn-on (0 = never) |
| turn_on_o | output | 1 | One-cycle turn-on request |
| count_o | output | 3 | Valleys counted in the present off-time |
| fault_o | output | 1 | Latched overvoltage fault |

## Verification
The hardest case to reach from the ports is the boundary of the blanking window. The bench must show that a burst one cycle shorter than the window leaves the latch clear, and that two such bursts with a brief gap do not add up to a fault. It does this by timing `ovp_cmp_i` in whole clock cycles from the falling clock edge. It then holds the input for a full window while the drive is high, and drops the drive partway through to show that only off-time cycles count. Saturation and the suppressed request at 7 are reached by running a long off-time with the target set to 7.

// File: rtl/valley_pkg.sv
// Package valley_pkg
// Shared widths and types for the valley counter block.
// Assumes: the valley count is a 3-bit quantity ranging 0..7.
package valley_pkg;
    localparam int          CNT_W   = 3;
    localparam logic [2:0]  CNT_MAX = 3'd7;

    typedef logic [CNT_W-1:0] vcount_t;
endpackage

// File: rtl/vc_sync.sv
// Module vc_sync
// Multi-flop synchronizer that brings an asynchronous comparator level into
// the clock domain.
// Assumes: STAGES >= 2; the input is a slow level, not a pulse shorter than a clock.
module vc_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] pipe_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // first capture flop samples the raw input
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[s] <= RST_VAL;
                    else        pipe_q[s] <= d_i;
                end
            end else begin : g_next
                // later flops resolve metastability
                always_ff @(posedge clk) begin
                    if (!rst_n) pipe_q[s] <= RST_VAL;
                    else        pipe_q[s] <= pipe_q[s-1];
                end
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/vc_valley_count.sv
// Module vc_valley_count
// Counts falling edges of the synchronized zero-crossing level while the
// drive is off, saturating at the package maximum. Clears on a drive rising
// edge and issues a one-cycle turn-on request on reaching the target.
// Assumes: drive_i is already in the clock domain; block_i is the next-cycle
// fault state so a request never coincides with a fresh fault.
module vc_valley_count
    import valley_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    zc_s_i,
    input  logic    drive_i,
    input  vcount_t target_i,
    input  logic    block_i,
    output vcount_t count_o,
    output logic    turn_on_o
);
    logic    zc_prev_q;
    logic    drive_prev_q;
    vcount_t count_q;
    vcount_t count_d;
    vcount_t count_inc;
    logic    turn_on_q;
    logic    zc_fall;
    logic    drive_rise;
    logic    step;
    logic    hit;

    // edge detection and next-count selection
    always_comb begin
        zc_fall    = zc_prev_q & ~zc_s_i;
        drive_rise = drive_i & ~drive_prev_q;
        step       = zc_fall & ~drive_i & (count_q != CNT_MAX);
        count_inc  = count_q + vcount_t'(1);
        hit        = step & (count_inc == target_i) & ~block_i;
        if (drive_rise)  count_d = '0;
        else if (step)   count_d = count_inc;
        else             count_d = count_q;
    end

    // history flops for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zc_prev_q    <= 1'b0;
            drive_prev_q <= 1'b0;
        end else begin
            zc_prev_q    <= zc_s_i;
            drive_prev_q <= drive_i;
        end
    end

    // valley count and request register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q   <= '0;
            turn_on_q <= 1'b0;
        end else begin
            count_q   <= count_d;
            turn_on_q <= hit & ~drive_rise;
        end
    end

    assign count_o   = count_q;
    assign turn_on_o = turn_on_q;
endmodule

// File: rtl/vc_ovp_guard.sv
// Module vc_ovp_guard
// Times how long the synchronized overvoltage level stays high during the
// off-time and latches a fault once it has lasted BLANK_CYCLES cycles.
// Assumes: BLANK_CYCLES >= 1; drive_i is in the clock domain.
module vc_ovp_guard #(
    parameter int BLANK_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovp_s_i,
    input  logic drive_i,
    output logic fault_o,
    output logic fault_next_o
);
    localparam int TW = (BLANK_CYCLES < 2) ? 1 : $clog2(BLANK_CYCLES);
    localparam logic [TW-1:0] LAST = TW'(BLANK_CYCLES - 1);

    logic [TW-1:0] timer_q;
    logic          fault_q;
    logic          qualify;
    logic          expire;

    // qualification of the overvoltage level and window expiry
    always_comb begin
        qualify      = ovp_s_i & ~drive_i;
        expire       = qualify & (timer_q == LAST);
        fault_next_o = fault_q | expire;
    end

    // blanking timer: restarts whenever the level drops or the drive turns on
    always_ff @(posedge clk) begin
        if (!rst_n)          timer_q <= '0;
        else if (!qualify)   timer_q <= '0;
        else if (!expire)    timer_q <= timer_q + TW'(1);
    end

    // sticky fault latch, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= 1'b0;
        else        fault_q <= fault_next_o;
    end

    assign fault_o = fault_q;
endmodule

// File: rtl/valley_counter_top.sv
// Module valley_counter_top
// Valley counter with turn-on request and overvoltage fault latch for a
// quasi-resonant switch controller.
// Assumes: comparator inputs are asynchronous levels; drive_on_i and target_i
// are synchronous to clk.
module valley_counter_top
    import valley_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int BLANK_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zc_cmp_i,
    input  logic       ovp_cmp_i,
    input  logic       drive_on_i,
    input  logic [2:0] target_i,
    output logic       turn_on_o,
    output logic [2:0] count_o,
    output logic       fault_o
);
    logic zc_s;
    logic ovp_s;
    logic fault_next;

    vc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_zc_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (zc_cmp_i),
        .q_o   (zc_s)
    );

    vc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ovp_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ovp_cmp_i),
        .q_o   (ovp_s)
    );

    vc_ovp_guard #(.BLANK_CYCLES(BLANK_CYCLES)) u_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovp_s_i      (ovp_s),
        .drive_i      (drive_on_i),
        .fault_o      (fault_o),
        .fault_next_o (fault_next)
    );

    vc_valley_count u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .zc_s_i    (zc_s),
        .drive_i   (drive_on_i),
        .target_i  (target_i),
        .block_i   (fault_next),
        .count_o   (count_o),
        .turn_on_o (turn_on_o)
    );
endmodule

// File: rtl/valley_counter_chk.sv
// Module valley_counter_chk
// Port-level properties of valley_counter_top, attached by bind.
// Assumes: SYNC_STAGES is small (it sets a $past depth).
module valley_counter_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ovp_cmp_i,
    input logic       drive_on_i,
    input logic [2:0] target_i,
    input logic       turn_on_o,
    input logic [2:0] count_o,
    input logic       fault_o
);
    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o != $past(count_o)) |-> (count_o == $past(count_o) + 3'd1 || count_o == 3'd0));

    // R2
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == 3'd7 && !drive_on_i) |=> (count_o == 3'd7));

    // R3
    drive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_on_i) |=> (count_o == 3'd0));

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on_o |=> !turn_on_o);

    // R5
    pulse_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on_o |-> (count_o == $past(target_i) && count_o != 3'd0));

    // R7
    fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o) |-> ($past(ovp_cmp_i, SYNC_STAGES + 1) && !$past(drive_on_i)));

    // R8
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    // R8
    fault_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> !turn_on_o);
endmodule

bind valley_counter_top valley_counter_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovp_cmp_i  (ovp_cmp_i),
    .drive_on_i (drive_on_i),
    .target_i   (target_i),
    .turn_on_o  (turn_on_o),
    .count_o    (count_o),
    .fault_o    (fault_o)
);

// File: tb/valley_counter_top_tb_top.sv
`timescale 1ns/1ps
module valley_counter_top_tb_top;
    localparam int BLANK = 8;
    localparam int HOLD  = 5;
    localparam int NVEC  = 31;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       zc = 1'b1;
    logic       ovp = 1'b0;
    logic       drive = 1'b1;
    logic [2:0] target = 3'd3;
    logic       turn_on;
    logic [2:0] count;
    logic       fault;

    int n_chk  = 0;
    int n_fail = 0;
    int pulses = 0;

    always #2.5 clk = ~clk;

    valley_counter_top #(.SYNC_STAGES(2), .BLANK_CYCLES(BLANK)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .zc_cmp_i   (zc),
        .ovp_cmp_i  (ovp),
        .drive_on_i (drive),
        .target_i   (target),
        .turn_on_o  (turn_on),
        .count_o    (count),
        .fault_o    (fault)
    );

    // turn-on high cycles, sampled mid-cycle; equals pulse count when each pulse is one cycle
    always @(negedge clk) begin
        if (!rst_n)       pulses <= 0;
        else if (turn_on) pulses <= pulses + 1;
    end

    // vector: {req[15:12], drive[11], zc[10], target[9:7], exp_count[6:4], exp_pulses[3:0]}
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {4'd3, 1'b1, 1'b1, 3'd3, 3'd0, 4'd0},  // R3 drive on
        {4'd1, 1'b0, 1'b1, 3'd3, 3'd0, 4'd0},  // R1 drive off, no edge
        {4'd1, 1'b0, 1'b0, 3'd3, 3'd1, 4'd0},  // R1 valley 1
        {4'd1, 1'b0, 1'b1, 3'd3, 3'd1, 4'd0},  // R1 rising ignored
        {4'd1, 1'b0, 1'b0, 3'd3, 3'd2, 4'd0},  // R1 valley 2
        {4'd1, 1'b0, 1'b1, 3'd3, 3'd2, 4'd0},
        {4'd5, 1'b0, 1'b0, 3'd3, 3'd3, 4'd1},  // R5 target reached
        {4'd5, 1'b0, 1'b1, 3'd3, 3'd3, 4'd1},
        {4'd5, 1'b0, 1'b0, 3'd3, 3'd4, 4'd1},  // R5 past target, no pulse
        {4'd3, 1'b1, 1'b1, 3'd3, 3'd0, 4'd1},  // R3 clear on drive rise
        {4'd4, 1'b1, 1'b0, 3'd3, 3'd0, 4'd1},  // R4 edge while drive on
        {4'd4, 1'b1, 1'b1, 3'd3, 3'd0, 4'd1},
        {4'd1, 1'b0, 1'b1, 3'd3, 3'd0, 4'd1},
        {4'd1, 1'b0, 1'b0, 3'd3, 3'd1, 4'd1},
        {4'd1, 1'b0, 1'b1, 3'd7, 3'd1, 4'd1},  // R5 target change alone
        {4'd1, 1'b0, 1'b0, 3'd7, 3'd2, 4'd1},
        {4'd1, 1'b0, 1'b1, 3'd7, 3'd2, 4'd1},
        {4'd1, 1'b0, 1'b0, 3'd7, 3'd3, 4'd1},
        {4'd1, 1'b0, 1'b1, 3'd7, 3'd3, 4'd1},
        {4'd1, 1'b0, 1'b0, 3'd7, 3'd4, 4'd1},
        {4'd1, 1'b0, 1'b1, 3'd7, 3'd4, 4'd1},
        {4'd1, 1'b0, 1'b0, 3'd7, 3'd5, 4'd1},
        {4'd1, 1'b0, 1'b1, 3'd7, 3'd5, 4'd1},
        {4'd1, 1'b0, 1'b0, 3'd7, 3'd6, 4'd1},
        {4'd1, 1'b0, 1'b1, 3'd7, 3'd6, 4'd1},
        {4'd5, 1'b0, 1'b0, 3'd7, 3'd7, 4'd2},  // R5 pulse at 7
        {4'd2, 1'b0, 1'b1, 3'd7, 3'd7, 4'd2},
        {4'd2, 1'b0, 1'b0, 3'd7, 3'd7, 4'd2},  // R2 saturate, no pulse
        {4'd2, 1'b0, 1'b1, 3'd7, 3'd7, 4'd2},
        {4'd2, 1'b0, 1'b0, 3'd7, 3'd7, 4'd2},  // R2 still 7
        {4'd3, 1'b1, 1'b1, 3'd7, 3'd0, 4'd2}   // R3 clear from 7
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cycles(3);
        check("R9 count in reset", count, 0);
        check("R9 fault in reset", fault, 0);
        rst_n = 1'b1;
        cycles(2);
    endtask

    initial begin
        #(200000 * 5.0);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R9 reset state
        cycles(3);
        check("R9 count", count, 0);
        check("R9 turn_on", turn_on, 0);
        check("R9 fault", fault, 0);
        rst_n = 1'b1;
        cycles(2);

        // table walk: R1..R5
        for (int v = 0; v < NVEC; v++) begin
            drive  = VEC[v][11];
            zc     = VEC[v][10];
            target = VEC[v][9:7];
            cycles(HOLD);
            check($sformatf("R%0d count vec %0d", VEC[v][15:12], v), count, VEC[v][6:4]);
            check($sformatf("R%0d pulses vec %0d", VEC[v][15:12], v), pulses, VEC[v][3:0]);
        end

        // R1 latency: count changes at the third edge after input change
        drive = 1'b0; zc = 1'b1; target = 3'd0;
        cycles(HOLD);
        zc = 1'b0;
        cycles(2);
        check("R1 count before third edge", count, 0);
        cycles(1);
        check("R1 count after third edge", count, 1);
        check("R5 target 0 gives no pulse", pulses, 2);

        // R6 overvoltage during drive on is ignored
        drive = 1'b1; zc = 1'b1;
        ovp = 1'b1;
        cycles(3 * BLANK);
        check("R6 fault with drive on", fault, 0);
        ovp = 1'b0;
        cycles(3);

        // R7 bursts one cycle short of the window, with restart
        drive = 1'b0;
        cycles(2);
        ovp = 1'b1; cycles(BLANK - 1); ovp = 1'b0; cycles(2);
        ovp = 1'b1; cycles(BLANK - 1); ovp = 1'b0; cycles(4);
        check("R7 short bursts", fault, 0);

        // R7 drive drops partway: only off-time counts
        drive = 1'b1; ovp = 1'b1;
        cycles(BLANK);
        drive = 1'b0;
        cycles(BLANK - 1);
        check("R7 window not yet full", fault, 0);
        cycles(2);
        check("R7 window full", fault, 1);

        // R8 sticky and blocks requests
        ovp = 1'b0;
        drive = 1'b1; cycles(HOLD);
        drive = 1'b0; target = 3'd1; zc = 1'b1; cycles(HOLD);
        zc = 1'b0; cycles(HOLD);
        check("R8 fault sticky", fault, 1);
        check("R8 count still runs", count, 1);
        check("R8 no request under fault", pulses, 2);

        // R8 reset clears fault
        do_reset();
        check("R8 fault after reset", fault, 0);

        // R7 exact window from a fresh reset
        drive = 1'b0; zc = 1'b1;
        cycles(2);
        ovp = 1'b1;
        cycles(BLANK);
        check("R7 fault at window edge", fault, 0);
        cycles(3);
        check("R7 fault after window", fault, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule